// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a real address by walking a radix tree held in memory. One translation begins with a one-cycle start strobe. Along with it come the effective address, the base address of the top directory, the number of index bits for that directory and the page-size exponent that the tree covers. The walker then reads one 64-bit entry per level through a request/acknowledge memory port. Each directory entry it reads gives the base and the index width of the next level. The walk stops at the first leaf entry, so a leaf found higher in the tree maps a larger page.

A walk ends in one of three ways. It can produce a real address together with the remaining page-size exponent and the leaf entry itself. It can fault because an entry read back with its valid bit clear. It can fault because the tree shape at some level is not one of the supported configurations. The result is flagged by a one-cycle done pulse and stays on the outputs until the next accepted start. Permission checks, caching of translations and nested translation are the job of surrounding logic.

Top module: `radix_walker`

## Requirements
- R1: After reset, mem_req_o, busy_o, done_o and fault_o are 0, cause_o is 2'b00, and raddr_o and leaf_o are zero.
- R2: Each entry read goes to address aligned_base + 8 * ((ea >> (psize - nls)) & (2^nls - 1)). Here psize and nls are the current page-size exponent and index width. Entry bit 63 is valid, bit 62 is leaf, a directory's next base is bits 59:8 (other bits zero) and its next index width is bits 4:0.
- R3: Before the entry address is formed, the low (nls + 3) bits of a directory base are forced to zero. This applies to the root base as well as to bases taken from directory entries.
- R4: Before each read, the level is checked against the supported shapes. Level 0 needs psize 52 and nls 13. Levels 1 and 2 need nls 9. Level 3 needs nls 9 or 5. Level 4 and beyond are never allowed. A failed check ends the walk with no read for that level, fault_o = 1 and cause_o = 2'b10.
- R5: An entry read with bit 63 clear ends the walk with fault_o = 1 and cause_o = 2'b01.
- R6: Each valid entry lowers the page-size exponent by the index width of its level. On success, psize_o is the exponent left after the leaf.
- R7: On success, raddr_o takes entry bits 56:12 with the low psize_o bits cleared, ORed with the low psize_o bits of the effective address, and leaf_o equals the leaf entry. On a fault, raddr_o and leaf_o are zero.
- R8: At most one read is outstanding. mem_req_o stays high with a stable mem_addr_o until mem_ack_i. A translation never makes more than four reads.
- R9: done_o is high for exactly one cycle per accepted start. The result outputs hold their values until the next accepted start.
- R10: A start while busy_o is high is ignored: the walk in progress finishes with its own result and produces a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin a translation |
| ea_i | input | 64 | Effective address to translate |
| root_base_i | input | 64 | Base address of the top directory |
| root_nls_i | input | 5 | Index width of the top directory |
| root_psize_i | input | 7 | Page-size exponent covered by the tree |
| mem_req_o | output | 1 | Read request, held until acknowledged |
| mem_addr_o | output | 64 | Byte address of the entry being read |
| mem_ack_i | input | 1 | Read acknowledge, with data valid in the same cycle |
| mem_rdata_i | input | 64 | Entry read from memory |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| raddr_o | output | 64 | Translated real address |
| psize_o | output | 7 | Final page-size exponent |
| leaf_o | output | 64 | Leaf entry that ended the walk |
| fault_o | output | 1 | The walk ended in a fault |
| cause_o | output | 2 | Fault cause: 01 no valid entry, 10 bad configuration |

## Verification
The assertions assume that memory raises mem_ack_i only while a request is pending, for a single cycle, and once per request. They also assume that start_i is a single-cycle strobe. The bench's memory model keeps to this: it answers each request once, after a latency of zero to two cycles, and never acknowledges when nothing is requested. Start is always driven for one cycle. The bench sweeps effective addresses across a tree built to contain leaves at every level, absent entries, a misaligned directory base, a 5-bit last level, an unsupported index width and an entry that leads past the deepest level. Separate walks cover a bad root shape and a start raised during a busy walk.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;
  localparam int ADDR_W     = 64;
  localparam int NLS_W      = 5;
  localparam int PSIZE_W    = 7;
  localparam int LVL_W      = 3;
  localparam int ENTRY_LOG2 = 3;
  localparam int VALID_BIT  = 63;
  localparam int LEAF_BIT   = 62;
  localparam int LAST_LEVEL = 3;
  localparam int MAX_READS  = LAST_LEVEL + 1;
  localparam int ROOT_PSIZE = 52;
  localparam int ROOT_NLS   = 13;
  localparam int DIR_NLS    = 9;
  localparam int TAIL_NLS   = 5;

  localparam logic [ADDR_W-1:0] NEXT_BASE_MASK = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [ADDR_W-1:0] PAGE_NUM_MASK  = 64'h01FF_FFFF_FFFF_F000;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_READ, S_EVAL, S_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_NO_ENTRY = 2'b01,
    CAUSE_BAD_CFG  = 2'b10
  } fault_cause_e;
endpackage

// File: rtl/radix_level_check.sv
module radix_level_check
  import radix_walk_pkg::*;
(
  input  logic [LVL_W-1:0]   level_i,
  input  logic [PSIZE_W-1:0] psize_i,
  input  logic [NLS_W-1:0]   nls_i,
  output logic               ok_o
);
  always_comb begin
    case (level_i)
      LVL_W'(0):             ok_o = (psize_i == PSIZE_W'(ROOT_PSIZE)) &&
                                    (nls_i == NLS_W'(ROOT_NLS));
      LVL_W'(1), LVL_W'(2):  ok_o = (nls_i == NLS_W'(DIR_NLS));
      LVL_W'(LAST_LEVEL):    ok_o = (nls_i == NLS_W'(DIR_NLS)) ||
                                    (nls_i == NLS_W'(TAIL_NLS));
      default:               ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/radix_entry_addr.sv
module radix_entry_addr
  import radix_walk_pkg::*;
(
  input  logic [ADDR_W-1:0]  ea_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [NLS_W-1:0]   nls_i,
  input  logic [PSIZE_W-1:0] psize_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [PSIZE_W-1:0] shift_amt;
  logic [NLS_W:0]     align_bits;
  logic [ADDR_W-1:0]  align_mask;
  logic [ADDR_W-1:0]  idx_mask;
  logic [ADDR_W-1:0]  index;

  always_comb begin
    shift_amt  = psize_i - PSIZE_W'(nls_i);
    align_bits = {1'b0, nls_i} + (NLS_W+1)'(ENTRY_LOG2);
    align_mask = (ADDR_W'(1) << align_bits) - ADDR_W'(1);
    idx_mask   = (ADDR_W'(1) << nls_i) - ADDR_W'(1);
    index      = (ea_i >> shift_amt) & idx_mask;
    addr_o     = (base_i & ~align_mask) + (index << ENTRY_LOG2);
  end
endmodule

// File: rtl/radix_leaf_form.sv
module radix_leaf_form
  import radix_walk_pkg::*;
(
  input  logic [ADDR_W-1:0]  entry_i,
  input  logic [ADDR_W-1:0]  ea_i,
  input  logic [PSIZE_W-1:0] psize_i,
  output logic [ADDR_W-1:0]  raddr_o
);
  logic [ADDR_W-1:0] off_mask;

  always_comb begin
    if (psize_i >= PSIZE_W'(ADDR_W)) off_mask = '1;
    else                             off_mask = (ADDR_W'(1) << psize_i) - ADDR_W'(1);
    raddr_o = (entry_i & PAGE_NUM_MASK & ~off_mask) | (ea_i & off_mask);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  ea_i,
  input  logic [ADDR_W-1:0]  root_base_i,
  input  logic [NLS_W-1:0]   root_nls_i,
  input  logic [PSIZE_W-1:0] root_psize_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_ack_i,
  input  logic [ADDR_W-1:0]  mem_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [ADDR_W-1:0]  raddr_o,
  output logic [PSIZE_W-1:0] psize_o,
  output logic [ADDR_W-1:0]  leaf_o,
  output logic               fault_o,
  output logic [1:0]         cause_o
);
  localparam int RD_CNT_W = $clog2(MAX_READS + 1) + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // walk context
  walk_state_e        state_q, state_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic [ADDR_W-1:0]  ea_q, ea_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [NLS_W-1:0]   nls_q, nls_d;
  logic [PSIZE_W-1:0] psize_q, psize_d;
  logic [ADDR_W-1:0]  ent_q, ent_d;
  logic               ctx_en;

  // result
  logic [ADDR_W-1:0]  raddr_q, raddr_d;
  logic [PSIZE_W-1:0] opsize_q, opsize_d;
  logic [ADDR_W-1:0]  leaf_q, leaf_d;
  logic               fault_q, fault_d;
  fault_cause_e       cause_q, cause_d;
  logic               res_en;

  logic               cfg_ok;
  logic [ADDR_W-1:0]  entry_addr;
  logic [ADDR_W-1:0]  leaf_raddr;
  logic [PSIZE_W-1:0] psize_rem;

  radix_level_check u_level_check (
    .level_i (lvl_q),
    .psize_i (psize_q),
    .nls_i   (nls_q),
    .ok_o    (cfg_ok)
  );

  radix_entry_addr u_entry_addr (
    .ea_i    (ea_q),
    .base_i  (base_q),
    .nls_i   (nls_q),
    .psize_i (psize_q),
    .addr_o  (entry_addr)
  );

  assign psize_rem = psize_q - PSIZE_W'(nls_q);

  radix_leaf_form u_leaf_form (
    .entry_i (ent_q),
    .ea_i    (ea_q),
    .psize_i (psize_rem),
    .raddr_o (leaf_raddr)
  );

  // next-state
  always_comb begin
    state_d  = state_q;
    lvl_d    = lvl_q;
    ea_d     = ea_q;
    base_d   = base_q;
    nls_d    = nls_q;
    psize_d  = psize_q;
    ent_d    = ent_q;
    ctx_en   = 1'b0;
    raddr_d  = raddr_q;
    opsize_d = opsize_q;
    leaf_d   = leaf_q;
    fault_d  = fault_q;
    cause_d  = cause_q;
    res_en   = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          ctx_en  = 1'b1;
          ea_d    = ea_i;
          base_d  = root_base_i;
          nls_d   = root_nls_i;
          psize_d = root_psize_i;
          lvl_d   = '0;
          state_d = S_CHECK;
        end
      end
      S_CHECK: begin
        if (cfg_ok) begin
          state_d = S_READ;
        end else begin
          res_en   = 1'b1;
          fault_d  = 1'b1;
          cause_d  = CAUSE_BAD_CFG;
          raddr_d  = '0;
          leaf_d   = '0;
          opsize_d = psize_q;
          state_d  = S_DONE;
        end
      end
      S_READ: begin
        if (mem_ack_i) begin
          ctx_en  = 1'b1;
          ent_d   = mem_rdata_i;
          state_d = S_EVAL;
        end
      end
      S_EVAL: begin
        if (!ent_q[VALID_BIT]) begin
          res_en   = 1'b1;
          fault_d  = 1'b1;
          cause_d  = CAUSE_NO_ENTRY;
          raddr_d  = '0;
          leaf_d   = '0;
          opsize_d = psize_q;
          state_d  = S_DONE;
        end else if (ent_q[LEAF_BIT]) begin
          res_en   = 1'b1;
          fault_d  = 1'b0;
          cause_d  = CAUSE_NONE;
          raddr_d  = leaf_raddr;
          leaf_d   = ent_q;
          opsize_d = psize_rem;
          state_d  = S_DONE;
        end else begin
          ctx_en  = 1'b1;
          psize_d = psize_rem;
          nls_d   = ent_q[NLS_W-1:0];
          base_d  = ent_q & NEXT_BASE_MASK;
          lvl_d   = lvl_q + LVL_W'(1);
          state_d = S_CHECK;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lvl_q   <= '0;
      ea_q    <= '0;
      base_q  <= '0;
      nls_q   <= '0;
      psize_q <= '0;
      ent_q   <= '0;
    end else if (ctx_en) begin
      lvl_q   <= lvl_d;
      ea_q    <= ea_d;
      base_q  <= base_d;
      nls_q   <= nls_d;
      psize_q <= psize_d;
      ent_q   <= ent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      raddr_q  <= '0;
      opsize_q <= '0;
      leaf_q   <= '0;
      fault_q  <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else if (res_en) begin
      raddr_q  <= raddr_d;
      opsize_q <= opsize_d;
      leaf_q   <= leaf_d;
      fault_q  <= fault_d;
      cause_q  <= cause_d;
    end
  end

  assign mem_req_o  = (state_q == S_READ);
  assign mem_addr_o = entry_addr;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign raddr_o    = raddr_q;
  assign psize_o    = opsize_q;
  assign leaf_o     = leaf_q;
  assign fault_o    = fault_q;
  assign cause_o    = cause_q;

  // reads per walk, kept for the read-limit check
  logic [RD_CNT_W-1:0] reads_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      reads_q <= '0;
    end else if (state_q == S_IDLE && start_i) begin
      reads_q <= '0;
    end else if (mem_req_o && mem_ack_i) begin
      reads_q <= reads_q + RD_CNT_W'(1);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))); // R8
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    reads_q <= RD_CNT_W'(MAX_READS)); // R8
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req_o |-> (lvl_q <= LVL_W'(LAST_LEVEL))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && !start_i) |=> ($stable(raddr_o) && $stable(leaf_o) &&
                               $stable(fault_o) && $stable(psize_o))); // R9
  AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> ($onehot0(cause_o) && (fault_o == (cause_o != 2'b00)))); // R5
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && !done_o && start_i) |=> busy_o); // R10
endmodule

// File: tb/test_radix_walker.sv
module test_radix_walker;
  localparam logic [63:0] NLB = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [63:0] RPN = 64'h01FF_FFFF_FFFF_F000;
  localparam logic [63:0] ROOT = 64'h0000_0000_0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ea = '0, root_base = '0;
  logic [4:0]  root_nls = '0;
  logic [6:0]  root_ps = '0;
  logic        mem_req, mem_ack = 1'b0;
  logic [63:0] mem_addr, mem_rdata = '0;
  logic        busy, done, fault;
  logic [63:0] raddr, leaf;
  logic [6:0]  psize;
  logic [1:0]  cause;

  always #4 clk = ~clk;

  radix_walker i_radix_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ea_i(ea),
    .root_base_i(root_base), .root_nls_i(root_nls), .root_psize_i(root_ps),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .raddr_o(raddr),
    .psize_o(psize), .leaf_o(leaf), .fault_o(fault), .cause_o(cause)
  );

  int errors = 0, checks = 0;
  logic [63:0] mem [logic [63:0]];

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] dir_e(input logic [63:0] b, input int n);
    return 64'h8000_0000_0000_0000 | (b & NLB) | 64'(n);
  endfunction

  function automatic logic [63:0] leaf_e(input int k);
    return 64'hC000_0000_0000_0000 | ((64'(k + 1) * 64'h9E37_79B9_7F4A_7C15) & RPN) | 64'h18F;
  endfunction

  // memory responder: one ack per request after 0..2 wait cycles
  int unsigned lat = 0, wcnt = 0;
  logic [63:0] got_addr [8];
  int got_n = 0;
  int done_cnt = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= rd(mem_addr);
        if (got_n < 8) got_addr[got_n] = mem_addr;
        got_n = got_n + 1;
        wcnt  = 0;
        lat   = (lat + 1) % 3;
      end else begin
        wcnt = wcnt + 1;
      end
    end
    if (done) done_cnt = done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected walk computed from the requirements
  logic [63:0] exp_addr [8];
  int          exp_n;
  logic [63:0] x_ra, x_leaf;
  logic [6:0]  x_ps;
  logic        x_flt;
  logic [1:0]  x_cause;

  task automatic model(input logic [63:0] a_ea, input logic [63:0] a_base,
                       input int a_nls, input int a_ps);
    logic [63:0] b, e, a, idx;
    int nl, p;
    bit ok;
    b = a_base; nl = a_nls; p = a_ps;
    exp_n = 0; x_flt = 0; x_cause = 2'b00; x_ra = '0; x_leaf = '0; x_ps = 7'(a_ps);
    for (int lvl = 0; lvl < 8; lvl++) begin
      ok = (lvl == 0) ? (p == 52 && nl == 13) :
           (lvl <= 2) ? (nl == 9) :
           (lvl == 3) ? (nl == 9 || nl == 5) : 1'b0;
      if (!ok) begin x_flt = 1; x_cause = 2'b10; return; end
      idx = (a_ea >> (p - nl)) & ((64'd1 << nl) - 64'd1);
      a = (b & ~((64'd1 << (nl + 3)) - 64'd1)) + idx * 64'd8;
      if (exp_n < 8) exp_addr[exp_n] = a;
      exp_n = exp_n + 1;
      e = rd(a);
      if (!e[63]) begin x_flt = 1; x_cause = 2'b01; return; end
      p = p - nl;
      if (e[62]) begin
        x_ps = 7'(p); x_leaf = e;
        x_ra = ((e & RPN) & ~((64'd1 << p) - 64'd1)) | (a_ea & ((64'd1 << p) - 64'd1));
        return;
      end
      nl = int'(e[4:0]);
      b  = e & NLB;
    end
  endtask

  task automatic run(input logic [63:0] a_ea, input logic [63:0] a_base, input int a_nls,
                     input int a_ps, input bit bump, input logic [63:0] bump_ea);
    int d0;
    logic [63:0] r_hold;
    model(a_ea, a_base, a_nls, a_ps);
    @(negedge clk);
    got_n = 0; d0 = done_cnt;
    start = 1'b1; ea = a_ea; root_base = a_base; root_nls = 5'(a_nls); root_ps = 7'(a_ps);
    @(negedge clk);
    start = 1'b0;
    if (bump) begin
      @(negedge clk);
      start = 1'b1; ea = bump_ea; root_base = a_base + 64'h100;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 400 && !done; t++) @(negedge clk);
    chk(done, "R9 done seen", 64'(done), 64'd1);
    chk(fault == x_flt, "R4/R5 fault flag", 64'(fault), 64'(x_flt));
    chk(cause == x_cause, "R4 R5 cause", 64'(cause), 64'(x_cause));
    chk(raddr == x_ra, "R7 real address", raddr, x_ra);
    chk(leaf == x_leaf, "R7 leaf entry", leaf, x_leaf);
    if (!x_flt) chk(psize == x_ps, "R6 page size", 64'(psize), 64'(x_ps));
    chk(got_n == exp_n, "R8 read count", 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < 8 && i < got_n; i++)
      chk(got_addr[i] == exp_addr[i], "R2 R3 entry address", got_addr[i], exp_addr[i]);
    r_hold = raddr;
    repeat (3) @(negedge clk);
    chk(!done, "R9 single-cycle done", 64'(done), 64'd0);
    chk(raddr == r_hold, "R9 result hold", raddr, r_hold);
    if (bump) chk(done_cnt - d0 == 1, "R10 start while busy ignored", 64'(done_cnt - d0), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired R9 actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;

  initial begin
    // tree
    mem[ROOT + 0*8] = dir_e(64'h10_0000, 9);
    mem[ROOT + 1*8] = leaf_e(1);
    mem[ROOT + 3*8] = dir_e(64'h18_0000, 8);
    mem[ROOT + 4*8] = dir_e(64'h20_0F00, 9);
    for (int i = 0; i < 4; i++) mem[64'h20_0000 + 64'(i*8)] = leaf_e(10 + i);
    mem[64'h10_0000 + 0*8] = dir_e(64'h11_0000, 9);
    mem[64'h10_0000 + 1*8] = leaf_e(3);
    mem[64'h10_0000 + 2*8] = dir_e(64'h12_0000, 9);
    mem[64'h11_0000 + 0*8] = dir_e(64'h13_0000, 9);
    mem[64'h11_0000 + 1*8] = leaf_e(4);
    mem[64'h11_0000 + 2*8] = dir_e(64'h14_0000, 5);
    mem[64'h11_0000 + 3*8] = dir_e(64'h15_0000, 7);
    for (int i = 0; i < 4; i++) mem[64'h13_0000 + 64'(i*8)] = leaf_e(20 + i);
    mem[64'h13_0000 + 5*8] = dir_e(64'h16_0000, 9);
    for (int i = 0; i < 32; i++) mem[64'h14_0000 + 64'(i*8)] = leaf_e(40 + i);

    repeat (4) @(negedge clk);
    chk(!mem_req && !busy, "R1 quiet in reset", 64'({mem_req, busy}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && !busy && !done, "R1 reset idle", 64'({mem_req, busy, done}), 64'd0);
    chk(!fault && cause == 2'b00, "R1 reset fault", 64'({fault, cause}), 64'd0);
    chk(raddr == 64'd0 && leaf == 64'd0, "R1 reset result", raddr | leaf, 64'd0);

    // sweep of the tree
    for (int i0 = 0; i0 < 5; i0++)
      for (int i1 = 0; i1 < 4; i1++)
        for (int i2 = 0; i2 < 5; i2++)
          for (int i3 = 0; i3 < 6; i3++) begin
            logic [63:0] v;
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            v = (64'(i0) << 39) | (64'(i1) << 30) | (64'(i2) << 21) | (64'(i3) << 12);
            v = v ^ (lcg & 64'hFFF0_0000_001F_0FFF);
            if (i3 < 3) v = v & 64'h000F_FFFF_FFE0_FFFF | (64'(i3) << 12);
            run(v, ROOT, 13, 52, 1'b0, 64'd0);
          end

    // root shapes: R3 misaligned root base, R4 bad root width and size
    run(64'h0000_0000_4000_1234, ROOT | 64'h1238, 13, 52, 1'b0, 64'd0);
    run(64'h0000_0000_0000_0000, ROOT, 12, 52, 1'b0, 64'd0);
    chk(got_n == 0, "R4 no read on bad root", 64'(got_n), 64'd0);
    run(64'h0000_0000_0000_0000, ROOT, 13, 48, 1'b0, 64'd0);
    // R8 deepest path: four reads then R4 fault
    run((64'd0 << 39) | (64'd0 << 30) | (64'd0 << 21) | (64'd5 << 12), ROOT, 13, 52, 1'b0, 64'd0);
    chk(got_n == 4 && cause == 2'b10, "R8 four reads max", 64'(got_n), 64'd4);
    // R10 start during busy walk
    run(64'h0000_0000_0020_3ABC, ROOT, 13, 52, 1'b1, 64'h0000_0080_0000_0000);
    run(64'h0000_0000_0000_1111, ROOT, 13, 52, 1'b1, 64'h0000_0000_4000_0000);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule